// File: doc/BRIEF.md
# Serial Addressed Register Loader

This block is the programming port of a two-channel frequency synthesizer. A host drives three wires: a serial clock, a serial data line and a load strobe. Each rising edge of the serial clock shifts one data bit into the block, most significant bit first. A frame is 22 bits long, and its last two bits form an address. When the load strobe rises, the block copies the shifted word into one of four holding registers. The address selects the register: one reference-divider register and one main-divider register for each channel. A main-divider register holds a swallow count and a program count.

All three wires are asynchronous to the chip. The block samples them with its own system clock, passes them through a multi-flop synchronizer and detects edges on the synchronized copies, so every register sits in the system clock domain. The serial clock's high and low phases, the data setup and hold, and the strobe width must each last several system clock periods. The frame's leading bits fall outside every field, so the block keeps only the last 20 bits it has shifted in.

The serial pins carry no back-pressure: the host owns the pace and the block accepts every edge it sees. A reference load whose divide value is below 3 is refused. The register keeps its old value and a reject flag pulses for one system clock. Each holding register reports whether it has taken a valid load since reset.

Top module: `serial_reg_loader`

## Requirements
- R1: After reset every divider output is zero, `loaded` is 4'b0000 and `ref_reject` is 0.
- R2: Each rising edge of `ser_clk` shifts `ser_dat` into the word, most significant bit first. The last bit shifted in becomes bit 0 of the word.
- R3: A rising edge of `ser_le` commits the word to the register addressed by its bits [1:0]. Code 2'b00 selects the channel-2 reference, 2'b01 the channel-1 reference, 2'b10 the channel-2 main divider and 2'b11 the channel-1 main divider.
- R4: A reference load takes its 15-bit divide value from word bits [16:2]. A value of 3 or more is accepted.
- R5: A main load takes its 7-bit swallow count from word bits [8:2] and its 11-bit program count from word bits [19:9].
- R6: A load changes only the addressed register. The other three registers keep their values.
- R7: A reference load with a divide value below 3 is ignored. The register keeps its old value and `ref_reject` is high for exactly one cycle.
- R8: Bit c of `loaded` (c = address code) rises on the first accepted load of register c and stays high until reset. An unloaded register reads zero.
- R9: Bits shifted with no following `ser_le` rising edge change no output. A later edge commits the shifted word.
- R10: Holding `ser_le` high does not load again. Only its rising edge commits a word.
- R11: A main load has no minimum value: a swallow count and a program count of zero are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Load strobe, commits on its rising edge |
| ref_ch1 | output | 15 | Channel-1 reference divide value |
| ref_ch2 | output | 15 | Channel-2 reference divide value |
| swal_ch1 | output | 7 | Channel-1 swallow count |
| prog_ch1 | output | 11 | Channel-1 program count |
| swal_ch2 | output | 7 | Channel-2 swallow count |
| prog_ch2 | output | 11 | Channel-2 program count |
| loaded | output | 4 | Per-address flag: register has taken a valid load |
| ref_reject | output | 1 | One-cycle pulse when a reference load is refused |

## Verification
The assertions check four things on every cycle. No output moves unless a load-strobe edge was detected. A refused reference load leaves both reference values untouched. The reject flag never lasts two cycles. A loaded flag never falls, and an unloaded register reads zero. Only the bench's scenarios can show the rest:
- the bit order and field positions of each word;
- the routing of each address code to the right register;
- the minimum divide value at the boundary of 3;
- that a word shifted without a strobe is committed by a later edge;
- that a strobe held high does not reload.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int CODE_W = 2;

  // Address carried in the last two bits of a frame.
  typedef enum logic [CODE_W-1:0] {
    SEL_REF_CH2  = 2'b00,
    SEL_REF_CH1  = 2'b01,
    SEL_MAIN_CH2 = 2'b10,
    SEL_MAIN_CH1 = 2'b11
  } sel_e;
endpackage

// File: rtl/srl_sync.sv
// Multi-stage synchronizer for a group of asynchronous pins.
module srl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] pins_q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stg[s] <= '0;
        else if (s == 0) stg[s] <= pins;
        else             stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pins_q = stg[STAGES-1];
endmodule

// File: rtl/srl_rise.sv
// Rising-edge detector on synchronized levels.
module srl_rise #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= '0;
    else        lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;
endmodule

// File: rtl/srl_shift.sv
// Shift register holding the trailing bits of a frame.
module srl_shift #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/srl_latch_bank.sv
// Address decode and the four holding registers.
module srl_latch_bank
  import srl_pkg::*;
#(
  parameter int REF_W   = 15,
  parameter int SWAL_W  = 7,
  parameter int PROG_W  = 11,
  parameter int MIN_REF = 3,
  localparam int MAIN_W = SWAL_W + PROG_W,
  localparam int KEEP_W = CODE_W + ((REF_W > MAIN_W) ? REF_W : MAIN_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_en,
  input  logic [KEEP_W-1:0]      word,
  output logic [1:0][REF_W-1:0]  ref_q,   // index 0 = channel 1
  output logic [1:0][SWAL_W-1:0] swal_q,
  output logic [1:0][PROG_W-1:0] prog_q,
  output logic [3:0]             flags,   // bit index = address code
  output logic                   ref_reject
);
  logic [CODE_W-1:0] code;
  logic [REF_W-1:0]  ref_field;
  logic [SWAL_W-1:0] swal_field;
  logic [PROG_W-1:0] prog_field;
  logic              ref_ok;
  logic [1:0]        ref_set, main_set;

  assign code       = word[CODE_W-1:0];
  assign ref_field  = word[CODE_W+REF_W-1:CODE_W];
  assign swal_field = word[CODE_W+SWAL_W-1:CODE_W];
  assign prog_field = word[CODE_W+MAIN_W-1:CODE_W+SWAL_W];
  assign ref_ok     = (ref_field >= REF_W'(MIN_REF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= '0;
      swal_q   <= '0;
      prog_q   <= '0;
      ref_set  <= '0;
      main_set <= '0;
    end else if (load_en) begin
      for (int ch = 0; ch < 2; ch++) begin
        // Channel 1 has code bit 0 set, channel 2 has it clear.
        if (code == {1'b0, ch == 0} && ref_ok) begin
          ref_q[ch]   <= ref_field;
          ref_set[ch] <= 1'b1;
        end
        if (code == {1'b1, ch == 0}) begin
          swal_q[ch]   <= swal_field;
          prog_q[ch]   <= prog_field;
          main_set[ch] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_reject <= 1'b0;
    else        ref_reject <= load_en && !code[1] && !ref_ok;
  end

  assign flags[SEL_REF_CH2]  = ref_set[1];
  assign flags[SEL_REF_CH1]  = ref_set[0];
  assign flags[SEL_MAIN_CH2] = main_set[1];
  assign flags[SEL_MAIN_CH1] = main_set[0];

  // R7
  reject_keeps_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_reject |-> $stable(ref_q));

  // R7
  reject_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_reject |=> !ref_reject);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags) & ~flags) == 4'b0000));

  // R8
  unloaded_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[SEL_REF_CH1] || ref_q[0] == '0) && (flags[SEL_REF_CH2] || ref_q[1] == '0)
    && (flags[SEL_MAIN_CH1] || (swal_q[0] == '0 && prog_q[0] == '0))
    && (flags[SEL_MAIN_CH2] || (swal_q[1] == '0 && prog_q[1] == '0)));
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
  import srl_pkg::*;
#(
  parameter int REF_W       = 15,
  parameter int SWAL_W      = 7,
  parameter int PROG_W      = 11,
  parameter int MIN_REF     = 3,
  parameter int SYNC_STAGES = 2,
  localparam int MAIN_W     = SWAL_W + PROG_W,
  localparam int KEEP_W     = CODE_W + ((REF_W > MAIN_W) ? REF_W : MAIN_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_le,
  output logic [REF_W-1:0]  ref_ch1,
  output logic [REF_W-1:0]  ref_ch2,
  output logic [SWAL_W-1:0] swal_ch1,
  output logic [PROG_W-1:0] prog_ch1,
  output logic [SWAL_W-1:0] swal_ch2,
  output logic [PROG_W-1:0] prog_ch2,
  output logic [3:0]        loaded,
  output logic              ref_reject
);
  logic [2:0]              pins_q;
  logic [1:0]              rise;
  logic [KEEP_W-1:0]       word;
  logic [1:0][REF_W-1:0]   ref_q;
  logic [1:0][SWAL_W-1:0]  swal_q;
  logic [1:0][PROG_W-1:0]  prog_q;

  // Data, clock and strobe pass through the same stages so they stay aligned.
  srl_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .pins({ser_le, ser_clk, ser_dat}), .pins_q(pins_q)
  );

  srl_rise #(.W(2)) rise_i (
    .clk(clk), .rst_n(rst_n), .lvl(pins_q[2:1]), .rise(rise)
  );

  srl_shift #(.W(KEEP_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .shift_en(rise[0]), .bit_in(pins_q[0]), .word(word)
  );

  srl_latch_bank #(
    .REF_W(REF_W), .SWAL_W(SWAL_W), .PROG_W(PROG_W), .MIN_REF(MIN_REF)
  ) bank_i (
    .clk(clk), .rst_n(rst_n), .load_en(rise[1]), .word(word),
    .ref_q(ref_q), .swal_q(swal_q), .prog_q(prog_q),
    .flags(loaded), .ref_reject(ref_reject)
  );

  assign ref_ch1  = ref_q[0];
  assign ref_ch2  = ref_q[1];
  assign swal_ch1 = swal_q[0];
  assign prog_ch1 = prog_q[0];
  assign swal_ch2 = swal_q[1];
  assign prog_ch2 = prog_q[1];

  // R9
  hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise[1] |=> $stable({ref_q, swal_q, prog_q, loaded}));
endmodule

// File: tb/serial_reg_loader_tb_top.sv
module serial_reg_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [14:0] ref_ch1, ref_ch2;
  logic [6:0]  swal_ch1, swal_ch2;
  logic [10:0] prog_ch1, prog_ch2;
  logic [3:0]  loaded;
  logic        ref_reject;

  int checks = 0, fails = 0, rej_cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_reg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .ref_ch1(ref_ch1), .ref_ch2(ref_ch2), .swal_ch1(swal_ch1), .prog_ch1(prog_ch1),
    .swal_ch2(swal_ch2), .prog_ch2(prog_ch2), .loaded(loaded), .ref_reject(ref_reject)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: pins seen two edges late, acted on one edge later.
  bit [21:0] m_sr;
  int m_ref[2], m_swal[2], m_prog[2];
  bit [3:0] m_loaded;
  bit m_err;
  bit hc1, hc2, hc3, hd1, hd2, hl1, hl2, hl3;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sr = '0; m_loaded = '0; m_err = 0;
      foreach (m_ref[i]) begin m_ref[i] = 0; m_swal[i] = 0; m_prog[i] = 0; end
      {hc1, hc2, hc3, hd1, hd2, hl1, hl2, hl3} = '0;
    end else begin
      m_err = 0;
      if (hl2 && !hl3) begin
        int code, ch, val;
        code = int'(m_sr[1:0]);
        ch   = (code % 2 == 1) ? 0 : 1;
        if (code < 2) begin
          val = int'(m_sr[16:2]);
          if (val >= 3) begin m_ref[ch] = val; m_loaded[code] = 1; end
          else m_err = 1;
        end else begin
          m_swal[ch] = int'(m_sr[8:2]);
          m_prog[ch] = int'(m_sr[19:9]);
          m_loaded[code] = 1;
        end
      end
      if (hc2 && !hc3) m_sr = {m_sr[20:0], hd2};
      hc3 = hc2; hc2 = hc1; hc1 = ser_clk;
      hd2 = hd1; hd1 = ser_dat;
      hl3 = hl2; hl2 = hl1; hl1 = ser_le;
    end
  end

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ref_ch1 == m_ref[0], "R4 ref_ch1", ref_ch1, m_ref[0]);
      chk(ref_ch2 == m_ref[1], "R4 ref_ch2", ref_ch2, m_ref[1]);
      chk(swal_ch1 == m_swal[0] && prog_ch1 == m_prog[0], "R5 main_ch1",
          {swal_ch1, prog_ch1}, {m_swal[0][6:0], m_prog[0][10:0]});
      chk(swal_ch2 == m_swal[1] && prog_ch2 == m_prog[1], "R5 main_ch2",
          {swal_ch2, prog_ch2}, {m_swal[1][6:0], m_prog[1][10:0]});
      chk(loaded == m_loaded, "R8 loaded", loaded, m_loaded);
      chk(ref_reject == m_err, "R7 ref_reject", ref_reject, m_err);
      if (ref_reject) rej_cycles++;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic shift_word(input bit [21:0] w);
    for (int i = 21; i >= 0; i--) begin
      ser_dat = w[i];
      wt(5);
      ser_clk = 1'b1;
      wt(5);
      ser_clk = 1'b0;
    end
    wt(5);
  endtask

  task automatic strobe();
    ser_le = 1'b1;
    wt(6);
    ser_le = 1'b0;
    wt(6);
  endtask

  function automatic bit [21:0] ref_word(input bit [1:0] code, input int val, input bit [4:0] junk);
    return {junk, val[14:0], code};
  endfunction

  function automatic bit [21:0] main_word(input bit [1:0] code, input int sw, input int pg, input bit [1:0] junk);
    return {junk, pg[10:0], sw[6:0], code};
  endfunction

  initial begin
    wt(4);
    rst_n = 1'b1;
    wt(1);
    // R1
    chk(ref_ch1 == 0 && ref_ch2 == 0 && swal_ch1 == 0 && prog_ch1 == 0 &&
        swal_ch2 == 0 && prog_ch2 == 0, "R1 values zero", ref_ch1 + ref_ch2, 0);
    chk(loaded == 0 && ref_reject == 0, "R1 flags clear", {loaded, ref_reject}, 0);

    shift_word(ref_word(2'b01, 1000, 5'h1F)); strobe();
    chk(ref_ch1 == 1000, "R3 code 01 to ch1 ref", ref_ch1, 1000);
    chk(ref_ch2 == 0, "R6 ch2 ref untouched", ref_ch2, 0);
    chk(loaded == 4'b0010, "R8 first load flag", loaded, 2);

    shift_word(ref_word(2'b00, 3, 5'h0A)); strobe();
    chk(ref_ch2 == 3, "R4 minimum divide accepted", ref_ch2, 3);

    shift_word(main_word(2'b10, 127, 2047, 2'b11)); strobe();
    chk(swal_ch2 == 127, "R5 swallow ch2", swal_ch2, 127);
    chk(prog_ch2 == 2047, "R5 program ch2", prog_ch2, 2047);
    chk(ref_ch1 == 1000, "R6 ch1 ref kept", ref_ch1, 1000);

    shift_word(main_word(2'b11, 0, 0, 2'b11)); strobe();
    chk(loaded[3] == 1'b1 && swal_ch1 == 0, "R11 zero main accepted", loaded, 15);

    shift_word(main_word(2'b11, 42, 1234, 2'b00)); strobe();
    chk(swal_ch1 == 42 && prog_ch1 == 1234, "R5 main ch1", {swal_ch1, prog_ch1}, {7'd42, 11'd1234});

    rej_cycles = 0;
    shift_word(ref_word(2'b01, 2, 5'h00)); strobe();
    chk(ref_ch1 == 1000, "R7 below minimum ignored", ref_ch1, 1000);
    chk(rej_cycles == 1, "R7 single reject pulse", rej_cycles, 1);

    rej_cycles = 0;
    shift_word(ref_word(2'b00, 0, 5'h03)); strobe();
    chk(ref_ch2 == 3 && rej_cycles == 1, "R7 zero divide ignored", ref_ch2, 3);

    shift_word(ref_word(2'b01, 777, 5'h00)); wt(10);
    chk(ref_ch1 == 1000, "R9 no strobe no change", ref_ch1, 1000);
    strobe();
    chk(ref_ch1 == 777, "R9 later strobe commits", ref_ch1, 777);

    ser_le = 1'b1; wt(6);
    shift_word(ref_word(2'b01, 555, 5'h00)); wt(10);
    chk(ref_ch1 == 777, "R10 held strobe no reload", ref_ch1, 777);
    ser_le = 1'b0; wt(6);

    shift_word(ref_word(2'b01, 16385, 5'h00)); strobe();
    chk(ref_ch1 == 16385, "R2 msb first order", ref_ch1, 16385);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule